// File: doc/BRIEF.md
# Three-Channel Timer Register Bank

This block is the memory-mapped configuration and interrupt front end for a group of three timer channels. A simple strobe bus (separate read and write enables, a byte address and a 32-bit data path) reaches every register. Each register kind sits in three consecutive words, one per channel, so the word offset divided by three selects the kind and the remainder selects the channel. The block holds the clock-control, counter-control, interval, three match, interrupt-enable and event-control fields and drives them straight out to the counter datapath. The live count and the live event count come back in from that datapath and can only be read.

Each channel reports six kinds of event as single-cycle pulses. The bank latches them into a sticky status register that a read returns and clears at once. A write to the status register changes nothing. Each channel has a level interrupt that is high while any latched status bit has its enable bit set. A write to counter control that sets the counter-clear bit does not store that bit. Instead it gives the datapath a one-cycle clear pulse.

Top module: `tmr3_regbank`

## Requirements
- R1: Only word-aligned byte addresses below 0x84 are mapped. For a mapped address, word = addr/4, register kind = word/3 and channel = word mod 3. The kinds in ascending order are: clock control, counter control, count, interval, match 1, match 2, match 3, interrupt status, interrupt enable, event control, event count.
- R2: After reset every counter-control field reads 0x21, every other stored field is 0, no clear pulse is active and all interrupt outputs are low.
- R3: A write stores only the low bits of the data: 6 for clock control, counter control and interrupt enable, 16 for interval and the match registers, 3 for event control. Each stored field appears on its output the cycle after the write.
- R4: Counter control is always stored with bit 4 clear. A write to it with data bit 4 set makes that channel's count_clear_o high for exactly the following cycle.
- R5: The count and event-count registers read back the channel's live 16-bit input, zero-extended. Writes to them change nothing.
- R6: An event pulse on evt_i bit b of a channel sets status bit b from the next cycle on, until a status read clears it. Bit 0 is interval, bits 1 to 3 are matches 1 to 3, bit 4 is counter overflow and bit 5 is event overflow.
- R7: A status read returns the bits latched before the read and clears them. An event pulse in the same cycle as the read stays set afterwards.
- R8: A write to the interrupt status register has no effect on any status bit.
- R9: irq_o of a channel is high exactly when the bitwise AND of its status and its interrupt enable is nonzero.
- R10: A read at an unmapped address returns 0, and a write there changes no register.
- R11: rdata_o is registered. It takes the read value on the clock edge where rd_en is high and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| count_i | input | 48 | Live 16-bit count per channel |
| evcnt_i | input | 48 | Live 16-bit event count per channel |
| evt_i | input | 18 | Six event pulses per channel |
| clk_ctrl_o | output | 18 | Clock-control field per channel |
| cnt_ctrl_o | output | 18 | Counter-control field per channel |
| interval_o | output | 48 | Interval field per channel |
| match_o | output | 144 | Three 16-bit match fields per channel |
| evctl_o | output | 9 | Event-control field per channel |
| count_clear_o | output | 3 | One-cycle counter clear pulse per channel |
| irq_o | output | 3 | Level interrupt per channel |

## Verification
The embedded assertions check, on every cycle, the local rules of the status register: a read clears it, a same-cycle event survives the read, a status write leaves it unchanged, and an enabled event raises the interrupt. They also check the clear pulse caused by counter-control writes, zero data from unmapped reads and the holding of read data between reads. The address interleave, the write masks, the reset values and the zero-extended live reads can only be shown by the bench's scenarios. There, a behavioural model of the whole register map is compared with every output on every cycle while all channels and kinds are written and read back.

// File: rtl/tmr3_regbank_pkg.sv
package tmr3_regbank_pkg;
    localparam int NUM_CH     = 3;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int NUM_MATCH  = 3;
    localparam int STAT_W     = 6;
    localparam int CLKC_W     = 6;
    localparam int CNTC_W     = 6;
    localparam int IEN_W      = 6;
    localparam int EVC_W      = 3;
    localparam int NUM_KINDS  = 11;
    localparam int KIND_W     = $clog2(NUM_KINDS);
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int MAP_WORDS  = NUM_CH * NUM_KINDS;
    localparam int CLR_BIT    = 4;
    localparam logic [CNTC_W-1:0] CNTC_RESET = 6'h21;

    // Ascending order is significant: it fixes the address of every kind.
    typedef enum logic [KIND_W-1:0] {
        K_CLKC, K_CNTC, K_COUNT, K_INTV, K_MATCH0, K_MATCH1, K_MATCH2,
        K_STAT, K_IEN, K_EVCTL, K_EVCNT
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [CH_W-1:0] chan;
    } dec_t;

    typedef struct packed {
        logic [CLKC_W-1:0]                 clk_ctrl;
        logic [CNTC_W-1:0]                 cnt_ctrl;
        logic [CNT_W-1:0]                  interval;
        logic [NUM_MATCH-1:0][CNT_W-1:0]   match;
        logic [IEN_W-1:0]                  ien;
        logic [EVC_W-1:0]                  evctl;
    } chan_cfg_t;

    function automatic reg_kind_e match_kind(input int idx);
        return reg_kind_e'(KIND_W'(int'(K_MATCH0) + idx));
    endfunction
endpackage

// File: rtl/tmr3_addr_dec.sv
module tmr3_addr_dec
    import tmr3_regbank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr_i,
    output dec_t          dec_o
);
    localparam int WORD_W = AW - 2;

    logic [WORD_W-1:0] word;
    assign word = addr_i[AW-1:2];

    always_comb begin
        dec_o = '0;
        if (addr_i[1:0] == 2'b00 && 32'(word) < MAP_WORDS) begin
            dec_o.hit  = 1'b1;
            dec_o.kind = reg_kind_e'(KIND_W'(32'(word) / NUM_CH));
            dec_o.chan = CH_W'(32'(word) % NUM_CH);
        end
    end
endmodule

// File: rtl/tmr3_chan_regs.sv
module tmr3_chan_regs
    import tmr3_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_stat,
    input  reg_kind_e         kind,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [STAT_W-1:0] evt_i,
    output chan_cfg_t         cfg_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              clear_o,
    output logic              irq_o
);
    chan_cfg_t         cfg_q;
    logic [STAT_W-1:0] stat_q;
    logic              clear_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q          <= '0;
            cfg_q.cnt_ctrl <= CNTC_RESET;
            clear_q        <= 1'b0;
        end else begin
            clear_q <= 1'b0;
            if (wr_en) begin
                case (kind)
                    K_CLKC:  cfg_q.clk_ctrl <= wdata[CLKC_W-1:0];
                    K_CNTC: begin
                        cfg_q.cnt_ctrl <= wdata[CNTC_W-1:0] & ~(CNTC_W'(1) << CLR_BIT);
                        clear_q        <= wdata[CLR_BIT];
                    end
                    K_INTV:  cfg_q.interval <= wdata;
                    K_IEN:   cfg_q.ien      <= wdata[IEN_W-1:0];
                    K_EVCTL: cfg_q.evctl    <= wdata[EVC_W-1:0];
                    default: ;
                endcase
                for (int i = 0; i < NUM_MATCH; i++) begin
                    if (kind == match_kind(i)) cfg_q.match[i] <= wdata;
                end
            end
        end
    end

    // Sticky status: a read clears it, a same-cycle event wins over the clear.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (rd_stat ? '0 : stat_q) | evt_i;
    end

    assign cfg_o   = cfg_q;
    assign stat_o  = stat_q;
    assign clear_o = clear_q;
    assign irq_o   = |(stat_q & cfg_q.ien);

    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && evt_i == '0) |=> stat_q == '0);
    // R7
    evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stat |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
    // R8
    stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == K_STAT && !rd_stat && evt_i == '0) |=> $stable(stat_q));
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(evt_i & cfg_q.ien)) && !(wr_en && kind == K_IEN)) |=> irq_o);
    // R4
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == K_CNTC && wdata[CLR_BIT]) |=> (clear_o && !cfg_o.cnt_ctrl[CLR_BIT]));
endmodule

// File: rtl/tmr3_regbank.sv
module tmr3_regbank
    import tmr3_regbank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [AW-1:0]                   addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata_o,
    input  logic [NUM_CH*CNT_W-1:0]         count_i,
    input  logic [NUM_CH*CNT_W-1:0]         evcnt_i,
    input  logic [NUM_CH*STAT_W-1:0]        evt_i,
    output logic [NUM_CH*CLKC_W-1:0]        clk_ctrl_o,
    output logic [NUM_CH*CNTC_W-1:0]        cnt_ctrl_o,
    output logic [NUM_CH*CNT_W-1:0]         interval_o,
    output logic [NUM_CH*NUM_MATCH*CNT_W-1:0] match_o,
    output logic [NUM_CH*EVC_W-1:0]         evctl_o,
    output logic [NUM_CH-1:0]               count_clear_o,
    output logic [NUM_CH-1:0]               irq_o
);
    dec_t              dec;
    chan_cfg_t         cfg  [NUM_CH];
    logic [STAT_W-1:0] stat [NUM_CH];
    logic [NUM_CH-1:0] wr_sel, rd_stat;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-CNT_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = wdata[DATA_W-1:CNT_W];

    tmr3_addr_dec #(.AW(AW)) dec_i (.addr_i(addr), .dec_o(dec));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_sel[c]  = wr_en && dec.hit && dec.chan == CH_W'(c);
        assign rd_stat[c] = rd_en && dec.hit && dec.chan == CH_W'(c) && dec.kind == K_STAT;

        tmr3_chan_regs ch_i (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_sel[c]),
            .rd_stat (rd_stat[c]),
            .kind    (dec.kind),
            .wdata   (wdata[CNT_W-1:0]),
            .evt_i   (evt_i[c*STAT_W +: STAT_W]),
            .cfg_o   (cfg[c]),
            .stat_o  (stat[c]),
            .clear_o (count_clear_o[c]),
            .irq_o   (irq_o[c])
        );

        assign clk_ctrl_o[c*CLKC_W +: CLKC_W] = cfg[c].clk_ctrl;
        assign cnt_ctrl_o[c*CNTC_W +: CNTC_W] = cfg[c].cnt_ctrl;
        assign interval_o[c*CNT_W +: CNT_W]   = cfg[c].interval;
        assign evctl_o[c*EVC_W +: EVC_W]      = cfg[c].evctl;
        for (genvar m = 0; m < NUM_MATCH; m++) begin : g_m
            assign match_o[(c*NUM_MATCH+m)*CNT_W +: CNT_W] = cfg[c].match[m];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dec.hit && dec.chan == CH_W'(c)) begin
                case (dec.kind)
                    K_CLKC:   rd_val = DATA_W'(cfg[c].clk_ctrl);
                    K_CNTC:   rd_val = DATA_W'(cfg[c].cnt_ctrl);
                    K_COUNT:  rd_val = DATA_W'(count_i[c*CNT_W +: CNT_W]);
                    K_INTV:   rd_val = DATA_W'(cfg[c].interval);
                    K_MATCH0: rd_val = DATA_W'(cfg[c].match[0]);
                    K_MATCH1: rd_val = DATA_W'(cfg[c].match[1]);
                    K_MATCH2: rd_val = DATA_W'(cfg[c].match[2]);
                    K_STAT:   rd_val = DATA_W'(stat[c]);
                    K_IEN:    rd_val = DATA_W'(cfg[c].ien);
                    K_EVCTL:  rd_val = DATA_W'(cfg[c].evctl);
                    K_EVCNT:  rd_val = DATA_W'(evcnt_i[c*CNT_W +: CNT_W]);
                    default:  rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_o <= '0;
        else if (rd_en) rdata_o <= rd_val;
    end

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.hit) |=> rdata_o == '0);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_o));
    // R1
    wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));
endmodule

// File: tb/tmr3_regbank_tb_top.sv
`timescale 1ns/1ps
module tmr3_regbank_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata_o;
    logic [47:0]  count_i = '0, evcnt_i = '0;
    logic [17:0]  evt_i = '0;
    logic [17:0]  clk_ctrl_o, cnt_ctrl_o;
    logic [47:0]  interval_o;
    logic [143:0] match_o;
    logic [8:0]   evctl_o;
    logic [2:0]   count_clear_o, irq_o;

    always #2.5 clk = ~clk;

    tmr3_regbank dut_i (.*);

    int checks = 0, fails = 0;

    // Behavioural model of the register map
    logic [5:0]  m_clk [3], m_cc [3], m_ier [3], m_isr [3];
    logic [15:0] m_iv  [3];
    logic [15:0] m_m   [3][3];
    logic [2:0]  m_ec  [3];
    logic        m_clr [3];
    logic [31:0] m_rdata;
    string       m_rtag = "R2";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_clk[c] = 0; m_cc[c] = 6'h21; m_ier[c] = 0; m_isr[c] = 0;
            m_iv[c] = 0; m_ec[c] = 0; m_clr[c] = 0;
            for (int i = 0; i < 3; i++) m_m[c][i] = 0;
        end
        m_rdata = 0;
    endtask

    task automatic model_step();
        bit hit; int w, k, c;
        w = int'(addr) / 4;
        hit = (addr % 4 == 0) && (w < 33);
        k = w / 3; c = w % 3;
        for (int j = 0; j < 3; j++) m_clr[j] = 0;
        if (rd_en) begin
            m_rdata = 0; m_rtag = "R10";
            if (hit) begin
                m_rtag = "R1";
                case (k)
                    0: m_rdata = {26'd0, m_clk[c]};
                    1: m_rdata = {26'd0, m_cc[c]};
                    2: begin m_rdata = {16'd0, count_i[c*16 +: 16]}; m_rtag = "R5"; end
                    3: m_rdata = {16'd0, m_iv[c]};
                    4, 5, 6: m_rdata = {16'd0, m_m[c][k-4]};
                    7: begin m_rdata = {26'd0, m_isr[c]}; m_rtag = "R7"; end
                    8: m_rdata = {26'd0, m_ier[c]};
                    9: m_rdata = {29'd0, m_ec[c]};
                    default: begin m_rdata = {16'd0, evcnt_i[c*16 +: 16]}; m_rtag = "R5"; end
                endcase
            end
        end
        for (int j = 0; j < 3; j++) begin
            if (rd_en && hit && k == 7 && c == j) m_isr[j] = 0;
            m_isr[j] = m_isr[j] | evt_i[j*6 +: 6];
        end
        if (wr_en && hit) begin
            case (k)
                0: m_clk[c] = wdata[5:0];
                1: begin m_cc[c] = wdata[5:0] & 6'h2F; m_clr[c] = wdata[4]; end
                3: m_iv[c] = wdata[15:0];
                4, 5, 6: m_m[c][k-4] = wdata[15:0];
                8: m_ier[c] = wdata[5:0];
                9: m_ec[c] = wdata[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        chk(m_rtag, rdata_o, m_rdata);                       // R11 registered read
        for (int c = 0; c < 3; c++) begin
            chk("R9", 32'(irq_o[c]), 32'(|(m_isr[c] & m_ier[c])));
            chk("R3", 32'(clk_ctrl_o[c*6 +: 6]), 32'(m_clk[c]));
            chk("R3", 32'(cnt_ctrl_o[c*6 +: 6]), 32'(m_cc[c]));
            chk("R3", 32'(interval_o[c*16 +: 16]), 32'(m_iv[c]));
            chk("R3", 32'(evctl_o[c*3 +: 3]), 32'(m_ec[c]));
            chk("R4", 32'(count_clear_o[c]), 32'(m_clr[c]));
            for (int i = 0; i < 3; i++)
                chk("R3", 32'(match_o[(c*3+i)*16 +: 16]), 32'(m_m[c][i]));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en = 0; rd_en = 0; evt_i = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1; addr = a; wdata = d; cycle();
    endtask

    task automatic rd(logic [7:0] a);
        rd_en = 1; addr = a; cycle();
    endtask

    function automatic logic [7:0] ra(int kind, int ch);
        return 8'(kind * 12 + ch * 4);
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        count_i = {16'hC0C2, 16'h8001, 16'h1234};
        evcnt_i = {16'hE0E2, 16'hFFFF, 16'h0007};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R2: reset state of every output
        compare_all();
        for (int c = 0; c < 3; c++) chk("R2", 32'(cnt_ctrl_o[c*6 +: 6]), 32'h21);
        chk("R2", 32'(irq_o), 0);

        // R2 readback of counter control, R1 interleave
        for (int c = 0; c < 3; c++) rd(ra(1, c));
        // R3 masks: all-ones and distinct patterns on every kind and channel
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 11; k++) begin
                if (k != 1) wr(ra(k, c), 32'hFFFF_FFFF);
            end
        end
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 11; k++) rd(ra(k, c));
        for (int c = 0; c < 3; c++)
            for (int k = 3; k < 7; k++) wr(ra(k, c), 32'h5A00_0000 | 32'((c+1) * 16'h1111 + k));
        for (int c = 0; c < 3; c++)
            for (int k = 3; k < 7; k++) rd(ra(k, c));
        // R4: clear bit stored as zero, pulse for one cycle
        wr(ra(1, 1), 32'hFFFF_FFFF);
        cycle();
        wr(ra(1, 2), 32'h0000_0006);
        rd(ra(1, 1)); rd(ra(1, 2));
        // R5: live counts, writes ignored
        wr(ra(2, 0), 32'h0000_BEEF);
        wr(ra(10, 2), 32'h0000_BEEF);
        rd(ra(2, 0)); rd(ra(2, 1)); rd(ra(10, 2));
        count_i[16 +: 16] = 16'hFFFF;
        rd(ra(2, 1));
        // R6: event latch, all six bits
        wr(ra(8, 0), 32'h0);
        for (int b = 0; b < 6; b++) begin
            evt_i[b] = 1; cycle();
        end
        rd(ra(7, 0)); rd(ra(7, 0));
        // R9: enable raises interrupt on latched status
        evt_i[6 +: 6] = 6'b010000; cycle();
        wr(ra(8, 1), 32'h10);
        wr(ra(8, 1), 32'h01);
        wr(ra(8, 1), 32'h10);
        // R7: event in the same cycle as the read survives
        rd_en = 1; addr = ra(7, 1); evt_i[6 +: 6] = 6'b000100; cycle();
        rd(ra(7, 1)); rd(ra(7, 1));
        // R8: status write has no effect
        evt_i[12 +: 6] = 6'b101010; cycle();
        wr(ra(7, 2), 32'h0);
        wr(ra(7, 2), 32'hFFFF_FFFF);
        rd(ra(7, 2));
        // R10: unmapped and misaligned accesses
        wr(8'h84, 32'hFFFF_FFFF); wr(8'h02, 32'h0); wr(8'hFC, 32'h1);
        rd(8'h84); rd(8'h02); rd(8'hFC); rd(8'h81);
        rd(ra(0, 0));
        // R11: hold while idle
        repeat (3) cycle();
        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            wr_en = r[0]; rd_en = r[1];
            addr = (r[2] ? 8'(r[15:8] % 8'd36) << 2 : r[23:16]);
            wdata = $urandom;
            evt_i = (r[3] ? 18'($urandom) : '0);
            count_i = {count_i[31:0], r[31:16]};
            cycle();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule